// File: doc/BRIEF.md
# Transceiver Reset and Power Sequencer

This block collects the reset, power-down and output-disable requests that reach a transceiver core and turns them into per-domain control lines. The core has a transmit half and a receive half. Each half holds a data-path block and a clock-multiplier (PLL) block, so the sequencer drives four reset lines, two PLL power-down lines, two PLL-stable flags and one output-enable for the embedded I/O.

There are several request sources. A power-up event, a configuration-busy flag, an active-low global reset that can be inhibited, a fabric reset request, a transmit-only reset pin and a receive-only reset pin all feed the reset lines. A PLL power-down request and a tri-state request act without resetting the core. Every reset line asserts as soon as any of its sources asserts, with no clock needed. A reset line releases only after its sources have been quiet for two rising edges of its own domain clock. When a PLL reset releases, a settle counter in that domain must run out before the PLL-stable flag rises. The settle length is a cycle-count parameter, sized to about 25 microseconds in a real system.

Top module: `rstpwr_ctrl`

## Requirements
- R1: While `pwrup_evt` is high, all four reset outputs are high and `io_oe` is low.
- R2: While `cfg_busy` is high, all four reset outputs are high and `io_oe` stays high.
- R3: While `glb_rst_n` is low and `glb_inh` is low, all four reset outputs are high. When `glb_inh` is high, a low `glb_rst_n` leaves every output unchanged, and a PLL that is already stable stays stable.
- R4: While `fab_rst` is high, all four reset outputs are high and `io_oe` stays high.
- R5: `tx_rst_req` drives only `tx_data_rst` and `tx_pll_rst`. `rx_rst_req` drives only `rx_data_rst` and `rx_pll_rst`.
- R6: While `pll_pd_req` is high, `tx_pll_pd` and `rx_pll_pd` are high, both PLL-stable flags are low, no reset output is raised and `io_oe` stays high.
- R7: While `io_hiz_req` is high, `io_oe` is low. No reset output is raised and a stable PLL stays stable.
- R8: A reset output goes high with no clock edge once a source for it asserts. After all its sources go low, it falls on the second rising edge of its domain clock.
- R9: After a PLL reset output falls, the matching PLL-stable flag stays low for SETTLE_CYCLES - 1 rising edges. It goes high on edge number SETTLE_CYCLES.
- R10: A new reset or power-down that arrives during the settle wait clears the wait. The full SETTLE_CYCLES count then starts again from the release.
- R11: For any mix of requests, each transmit reset equals the OR of pwrup, cfg, enabled global, fabric and transmit sources. Each receive reset is the same with the receive source. `io_oe` is the NOR of `pwrup_evt` and `io_hiz_req`. Both power-down outputs follow `pll_pd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit domain clock |
| rx_clk | input | 1 | Receive domain clock |
| pwrup_evt | input | 1 | Power-up event, active high |
| cfg_busy | input | 1 | Configuration in progress, active high |
| glb_rst_n | input | 1 | Global reset, active low |
| glb_inh | input | 1 | Inhibit for the global reset |
| fab_rst | input | 1 | Reset request from fabric logic |
| tx_rst_req | input | 1 | Transmit-only reset pin |
| rx_rst_req | input | 1 | Receive-only reset pin |
| pll_pd_req | input | 1 | PLL power-down request |
| io_hiz_req | input | 1 | Tri-state request for the embedded I/O |
| tx_data_rst | output | 1 | Reset to the transmit data block |
| tx_pll_rst | output | 1 | Reset to the transmit PLL |
| rx_data_rst | output | 1 | Reset to the receive data block |
| rx_pll_rst | output | 1 | Reset to the receive PLL |
| tx_pll_pd | output | 1 | Transmit PLL power-down |
| rx_pll_pd | output | 1 | Receive PLL power-down |
| tx_pll_stable | output | 1 | Transmit PLL settled |
| rx_pll_stable | output | 1 | Receive PLL settled |
| io_oe | output | 1 | Output enable for the embedded I/O |

## Verification
The assertions check the following on every clock edge:
- a domain-only request always holds its own domain in reset;
- power-down and tri-state always reach their outputs;
- a PLL-stable flag is never high while its PLL is in reset or powered down;
- a reset line falls only after its combined source was already quiet.

The bench scenarios cover what needs a timeline or the full table:
- the immediate assertion with no clock edge;
- the exact release edge and the exact settle edge;
- the settle restart after a late reset or power-down;
- the inhibited global reset;
- a sweep of all 512 request mixes against the OR table.

// File: rtl/rstpwr_pkg.sv
package rstpwr_pkg;

  typedef struct packed {
    logic pwrup;
    logic cfg;
    logic glb_n;
    logic glb_inh;
    logic fab;
    logic tx_req;
    logic rx_req;
    logic pd_req;
    logic hiz_req;
  } rp_src_t;

  typedef enum logic {
    DOM_TX = 1'b0,
    DOM_RX = 1'b1
  } rp_dom_e;

  localparam int unsigned RP_NUM_DOM = 2;
  localparam int unsigned RP_NUM_BLK = 2;  // data block, PLL block

  // Global reset counts only when not inhibited.
  function automatic logic rp_glb_active(rp_src_t s);
    return !s.glb_n && !s.glb_inh;
  endfunction

  // Sources that hit both halves of the core.
  function automatic logic rp_common_rst(rp_src_t s);
    return s.pwrup | s.cfg | rp_glb_active(s) | s.fab;
  endfunction

  function automatic logic rp_dom_rst(rp_src_t s, rp_dom_e d);
    logic own;
    own = (d == DOM_TX) ? s.tx_req : s.rx_req;
    return rp_common_rst(s) | own;
  endfunction

  function automatic logic rp_io_drive(rp_src_t s);
    return !(s.pwrup | s.hiz_req);
  endfunction

  function automatic int unsigned rp_cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rp_src_map.sv
module rp_src_map
  import rstpwr_pkg::*;
(
  input  rp_src_t                 src,
  output logic [RP_NUM_DOM-1:0]   dom_rst_raw,
  output logic [RP_NUM_DOM-1:0]   dom_pd_raw,
  output logic                    io_drive
);

  for (genvar d = 0; d < RP_NUM_DOM; d++) begin : g_dom
    always_comb begin
      dom_rst_raw[d] = rp_dom_rst(src, rp_dom_e'(d));
      dom_pd_raw[d]  = src.pd_req;
    end
  end

  always_comb io_drive = rp_io_drive(src);

endmodule

// File: rtl/rp_rel_sync.sv
module rp_rel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);

  logic [STAGES-1:0] chain_q;

  // Set at once on the async reset, clear one stage per clock edge.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= '1;
    else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];

endmodule

// File: rtl/rp_settle_tmr.sv
module rp_settle_tmr
  import rstpwr_pkg::*;
#(
  parameter int unsigned CYCLES = 3907
) (
  input  logic clk,
  input  logic arst,
  output logic stable
);

  localparam int unsigned CW = rp_cnt_w(CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == LIMIT);

  // Count up from zero and stop at the limit.
  always_ff @(posedge clk or posedge arst) begin
    if (arst)       cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end

  assign stable = done;

endmodule

// File: rtl/rstpwr_ctrl.sv
module rstpwr_ctrl
  import rstpwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 3907
) (
  input  logic tx_clk,
  input  logic rx_clk,
  input  logic pwrup_evt,
  input  logic cfg_busy,
  input  logic glb_rst_n,
  input  logic glb_inh,
  input  logic fab_rst,
  input  logic tx_rst_req,
  input  logic rx_rst_req,
  input  logic pll_pd_req,
  input  logic io_hiz_req,
  output logic tx_data_rst,
  output logic tx_pll_rst,
  output logic rx_data_rst,
  output logic rx_pll_rst,
  output logic tx_pll_pd,
  output logic rx_pll_pd,
  output logic tx_pll_stable,
  output logic rx_pll_stable,
  output logic io_oe
);

  localparam int unsigned BLK_DATA = 0;
  localparam int unsigned BLK_PLL  = 1;

  rp_src_t                 src;
  logic [RP_NUM_DOM-1:0]   dom_clk;
  logic [RP_NUM_DOM-1:0]   dom_rst_raw;   // combined async request per domain
  logic [RP_NUM_DOM-1:0]   dom_pd_raw;
  logic [RP_NUM_DOM-1:0]   tmr_clr;       // settle timer clear per domain
  logic [RP_NUM_DOM-1:0]   dom_stable;
  logic                    io_drive;
  logic [RP_NUM_BLK-1:0]   blk_rst [RP_NUM_DOM];

  always_comb begin
    src.pwrup   = pwrup_evt;
    src.cfg     = cfg_busy;
    src.glb_n   = glb_rst_n;
    src.glb_inh = glb_inh;
    src.fab     = fab_rst;
    src.tx_req  = tx_rst_req;
    src.rx_req  = rx_rst_req;
    src.pd_req  = pll_pd_req;
    src.hiz_req = io_hiz_req;
  end

  assign dom_clk[DOM_TX] = tx_clk;
  assign dom_clk[DOM_RX] = rx_clk;

  rp_src_map u_map (
    .src         (src),
    .dom_rst_raw (dom_rst_raw),
    .dom_pd_raw  (dom_pd_raw),
    .io_drive    (io_drive)
  );

  for (genvar d = 0; d < RP_NUM_DOM; d++) begin : g_dom
    for (genvar b = 0; b < RP_NUM_BLK; b++) begin : g_blk
      rp_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (dom_clk[d]),
        .arst  (dom_rst_raw[d]),
        .rst_o (blk_rst[d][b])
      );
    end

    assign tmr_clr[d] = blk_rst[d][BLK_PLL] | dom_pd_raw[d];

    rp_settle_tmr #(.CYCLES(SETTLE_CYCLES)) u_tmr (
      .clk    (dom_clk[d]),
      .arst   (tmr_clr[d]),
      .stable (dom_stable[d])
    );
  end

  assign tx_data_rst   = blk_rst[DOM_TX][BLK_DATA];
  assign tx_pll_rst    = blk_rst[DOM_TX][BLK_PLL];
  assign rx_data_rst   = blk_rst[DOM_RX][BLK_DATA];
  assign rx_pll_rst    = blk_rst[DOM_RX][BLK_PLL];
  assign tx_pll_pd     = dom_pd_raw[DOM_TX];
  assign rx_pll_pd     = dom_pd_raw[DOM_RX];
  assign tx_pll_stable = dom_stable[DOM_TX];
  assign rx_pll_stable = dom_stable[DOM_RX];
  assign io_oe         = io_drive;

endmodule

// File: rtl/rstpwr_ctrl_chk.sv
module rstpwr_ctrl_chk (
  input logic       tx_clk,
  input logic       rx_clk,
  input logic       pwrup_evt,
  input logic       tx_rst_req,
  input logic       rx_rst_req,
  input logic       pll_pd_req,
  input logic       io_hiz_req,
  input logic       tx_data_rst,
  input logic       tx_pll_rst,
  input logic       rx_data_rst,
  input logic       rx_pll_rst,
  input logic       tx_pll_pd,
  input logic       rx_pll_pd,
  input logic       tx_pll_stable,
  input logic       rx_pll_stable,
  input logic       io_oe,
  input logic [1:0] dom_rst_raw
);

  a_r5_tx_req_holds_tx: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    tx_rst_req |-> (tx_data_rst && tx_pll_rst));

  a_r5_rx_req_holds_rx: assert property (@(posedge rx_clk) disable iff (pwrup_evt)
    rx_rst_req |-> (rx_data_rst && rx_pll_rst));

  a_r6_pd_reaches_plls: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    pll_pd_req |-> (tx_pll_pd && rx_pll_pd));

  a_r7_hiz_blocks_oe: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    io_hiz_req |-> !io_oe);

  a_r9_tx_stable_clean: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    tx_pll_stable |-> (!tx_pll_rst && !tx_pll_pd));

  a_r9_rx_stable_clean: assert property (@(posedge rx_clk) disable iff (pwrup_evt)
    rx_pll_stable |-> (!rx_pll_rst && !rx_pll_pd));

  a_r8_tx_release_after_quiet: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    $fell(tx_data_rst) |-> !$past(dom_rst_raw[0]));

  a_r8_rx_release_after_quiet: assert property (@(posedge rx_clk) disable iff (pwrup_evt)
    $fell(rx_data_rst) |-> !$past(dom_rst_raw[1]));

  a_r9_tx_rise_after_release: assert property (@(posedge tx_clk) disable iff (pwrup_evt)
    $rose(tx_pll_stable) |-> $past(!tx_pll_rst));

endmodule

bind rstpwr_ctrl rstpwr_ctrl_chk chk_i (
  .tx_clk        (tx_clk),
  .rx_clk        (rx_clk),
  .pwrup_evt     (pwrup_evt),
  .tx_rst_req    (tx_rst_req),
  .rx_rst_req    (rx_rst_req),
  .pll_pd_req    (pll_pd_req),
  .io_hiz_req    (io_hiz_req),
  .tx_data_rst   (tx_data_rst),
  .tx_pll_rst    (tx_pll_rst),
  .rx_data_rst   (rx_data_rst),
  .rx_pll_rst    (rx_pll_rst),
  .tx_pll_pd     (tx_pll_pd),
  .rx_pll_pd     (rx_pll_pd),
  .tx_pll_stable (tx_pll_stable),
  .rx_pll_stable (rx_pll_stable),
  .io_oe         (io_oe),
  .dom_rst_raw   (dom_rst_raw)
);

// File: tb/rstpwr_ctrl_tb_top.sv
module rstpwr_ctrl_tb_top;

  localparam int unsigned SETTLE = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic pwrup_evt, cfg_busy, glb_rst_n, glb_inh, fab_rst;
  logic tx_rst_req, rx_rst_req, pll_pd_req, io_hiz_req;
  logic tx_data_rst, tx_pll_rst, rx_data_rst, rx_pll_rst;
  logic tx_pll_pd, rx_pll_pd, tx_pll_stable, rx_pll_stable, io_oe;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  rstpwr_ctrl #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) dut_i (
    .tx_clk(clk), .rx_clk(clk),
    .pwrup_evt(pwrup_evt), .cfg_busy(cfg_busy), .glb_rst_n(glb_rst_n),
    .glb_inh(glb_inh), .fab_rst(fab_rst), .tx_rst_req(tx_rst_req),
    .rx_rst_req(rx_rst_req), .pll_pd_req(pll_pd_req), .io_hiz_req(io_hiz_req),
    .tx_data_rst(tx_data_rst), .tx_pll_rst(tx_pll_rst),
    .rx_data_rst(rx_data_rst), .rx_pll_rst(rx_pll_rst),
    .tx_pll_pd(tx_pll_pd), .rx_pll_pd(rx_pll_pd),
    .tx_pll_stable(tx_pll_stable), .rx_pll_stable(rx_pll_stable), .io_oe(io_oe)
  );

  // Packed view: {txd, txp, rxd, rxp, txpd, rxpd, oe}
  function automatic logic [6:0] outs();
    return {tx_data_rst, tx_pll_rst, rx_data_rst, rx_pll_rst,
            tx_pll_pd, rx_pll_pd, io_oe};
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  // Input order: {pwrup, cfg, glb_n, inh, fab, tx, rx, pd, hiz}
  task automatic drive(logic [8:0] v);
    {pwrup_evt, cfg_busy, glb_rst_n, glb_inh, fab_rst,
     tx_rst_req, rx_rst_req, pll_pd_req, io_hiz_req} = v;
  endtask

  localparam logic [8:0] QUIET = 9'b001_000_000;

  task automatic quiet_settle();
    drive(QUIET);
    repeat (SETTLE + 4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic row(string tag, logic [8:0] v, logic [6:0] exp);
    @(negedge clk);
    drive(v);
    #1;
    chk(tag, {2'b00, outs()}, {2'b00, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    drive(9'b101_000_000);
    #1;
    chk("R1 reset state", {outs(), tx_pll_stable, rx_pll_stable}, {7'b1111_000, 2'b00});
    repeat (3) @(posedge clk);
    quiet_settle();
    chk("R9 stable after startup", {7'b0, tx_pll_stable, rx_pll_stable}, {7'b0, 2'b11});

    // Directed rows of the source table
    row("R1 power-up", 9'b101_000_000, 7'b1111_000); quiet_settle();
    row("R2 config",   9'b011_000_000, 7'b1111_001); quiet_settle();
    row("R3 global",   9'b000_000_000, 7'b1111_001); quiet_settle();
    row("R3 inhibited global", 9'b000_100_000, 7'b0000_001);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R3 inhibited keeps stable", {outs(), tx_pll_stable, rx_pll_stable},
        {7'b0000_001, 2'b11});
    quiet_settle();
    row("R4 fabric",   9'b001_010_000, 7'b1111_001); quiet_settle();
    row("R5 tx only",  9'b001_001_000, 7'b1100_001); quiet_settle();
    row("R5 rx only",  9'b001_000_100, 7'b0011_001); quiet_settle();
    row("R6 power-down", 9'b001_000_010, 7'b0000_111);
    @(posedge clk); @(negedge clk);
    chk("R6 stable low in pd", {7'b0, tx_pll_stable, rx_pll_stable}, 9'b0);
    quiet_settle();
    row("R7 tri-state", 9'b001_000_001, 7'b0000_000);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R7 stable kept", {7'b0, tx_pll_stable, rx_pll_stable}, {7'b0, 2'b11});
    quiet_settle();

    // R8: async assert, release on the second edge
    row("R8 async assert", 9'b001_001_000, 7'b1100_001);
    @(negedge clk); drive(QUIET);
    @(posedge clk); @(negedge clk);
    chk("R8 held after one edge", {7'b0, tx_data_rst, tx_pll_rst}, {7'b0, 2'b11});
    @(posedge clk); @(negedge clk);
    chk("R8 released on second edge", {7'b0, tx_data_rst, tx_pll_rst}, 9'b0);
    // R9: settle count
    for (int k = 1; k <= SETTLE; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == SETTLE - 1 || k == SETTLE)
        chk("R9 settle edge", {8'b0, tx_pll_stable}, {8'b0, k == SETTLE});
    end

    // R10: power-down during the wait restarts it
    row("R10 reset for restart", 9'b001_001_000, 7'b1100_001);
    @(negedge clk); drive(QUIET);
    repeat (2 + 5) @(posedge clk);
    @(negedge clk); drive(9'b001_000_010);
    @(negedge clk); drive(QUIET);
    for (int k = 1; k <= SETTLE; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == SETTLE - 1 || k == SETTLE)
        chk("R10 pd restart", {8'b0, tx_pll_stable}, {8'b0, k == SETTLE});
    end
    // R10: late reset during the wait restarts it
    row("R10 reset again", 9'b001_001_000, 7'b1100_001);
    @(negedge clk); drive(QUIET);
    repeat (2 + 4) @(posedge clk);
    @(negedge clk); drive(9'b001_001_000);
    @(negedge clk); drive(QUIET);
    repeat (2) @(posedge clk);
    for (int k = 1; k <= SETTLE; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == SETTLE - 1 || k == SETTLE)
        chk("R10 reset restart", {8'b0, tx_pll_stable}, {8'b0, k == SETTLE});
    end

    // R11: every mix of requests against the OR table
    for (int i = 0; i < 512; i++) begin
      logic [8:0] v;
      logic p, c, g, h, f, t, r, d, z, com;
      v = 9'(i);
      {p, c, g, h, f, t, r, d, z} = v;
      com = p | c | (!g & !h) | f;
      row("R11 sweep", v, {com | t, com | t, com | r, com | r, d, d, !(p | z)});
      @(negedge clk); drive(QUIET);
      repeat (3) @(posedge clk);
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule